// File: doc/BRIEF.md
# Saturating Multiply-Accumulate Register Pair

This block keeps a signed 64-bit running sum in two 32-bit halves, an upper word and a lower word, and adds one signed product to it for each strobe. In long mode the whole 32-bit operands are multiplied. In word mode only the low 16 bits of each operand are used, each sign-extended, so the bits above them do not matter. The updated pair can be read one cycle after the strobe.

A saturation enable changes how the sum is written back, and each mode treats it differently. In long mode the sign of the sum decides the outcome. A negative sum forces the top half of the upper word to ones. Any other sum keeps only the low 15 bits of the upper word. In word mode the sum is clamped to the signed 32-bit range. When a clamp happens, the upper word is set to 1 to mark the overflow.

Software can clear both halves at once or load either half directly. This is how the sum is preset before a run and read out afterwards.

Top module: `mac_pair_acc`

## Requirements
- R1: After reset both halves read 0.
- R2: In long mode with saturation off, a strobe adds the signed 64-bit product of the two 32-bit operands to {hi,lo}, modulo 2^64. The new value is on the read ports at the first clock edge after the strobe, and back-to-back strobes accumulate.
- R3: In word mode with saturation off, a strobe sign-extends bits [15:0] of each operand, multiplies them and adds the product to {hi,lo}. No clamp is applied even when the sum leaves the 32-bit range.
- R4: In long mode with saturation on, the lower word is the plain sum. If bit 63 of the sum is 1, the upper word is the sum's upper word with bits [31:16] forced to 1. Otherwise the upper word is the sum's upper word with bits [31:15] cleared.
- R5: In word mode with saturation on, a sum below -2^31 writes 1 to the upper word and 0x80000000 to the lower word.
- R6: In word mode with saturation on, a sum above 2^31-1 writes 1 to the upper word and 0x7FFFFFFF to the lower word.
- R7: In word mode with saturation on, a sum inside [-2^31, 2^31-1] is written back unchanged.
- R8: Clear sets both halves to 0 at the next edge, overriding a strobe or direct writes in the same cycle.
- R9: A direct write loads its half at the next edge. It overrides that half of a strobe result in the same cycle, and the other half still takes the strobe result.
- R10: With no strobe, clear or write, both halves hold their value.
- R11: In word mode, operand bits [31:16] have no effect on the result.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| op_valid | input | 1 | Multiply-accumulate strobe |
| op_word | input | 1 | Mode: 0 long (32x32), 1 word (16x16) |
| sat_en | input | 1 | Saturation enable |
| clr | input | 1 | Zero both halves |
| opnd_a | input | 32 | First signed operand |
| opnd_b | input | 32 | Second signed operand |
| hi_we | input | 1 | Upper word write enable |
| hi_wdata | input | 32 | Upper word write data |
| lo_we | input | 1 | Lower word write enable |
| lo_wdata | input | 32 | Lower word write data |
| hi_rdata | output | 32 | Upper word of the sum |
| lo_rdata | output | 32 | Lower word of the sum |

## Verification
The bench builds the block with its default widths: 32-bit words and a 16-bit narrow operand. With these widths every clamp boundary can be hit exactly from a direct preset. This covers the sums 2^31 and -2^31-1 in word mode and a carry from the lower word into the upper one. It also covers the largest long-mode product, 2^62, and the sign flip that decides the long-mode mask. Operands with nonzero upper bits in word mode show that those bits are ignored.

// File: rtl/mac_pkg.sv
package mac_pkg;
  typedef enum logic {
    MODE_LONG = 1'b0,
    MODE_WORD = 1'b1
  } mac_mode_e;
endpackage

// File: rtl/mac_product.sv
module mac_product
  import mac_pkg::*;
#(
  parameter int WORD_W   = 32,
  parameter int NARROW_W = 16
) (
  input  mac_mode_e             mode,
  input  logic [WORD_W-1:0]     opnd_a,
  input  logic [WORD_W-1:0]     opnd_b,
  output logic [2*WORD_W-1:0]   prod
);
  localparam int PW = 2 * WORD_W;

  logic signed [PW-1:0] a_ext;
  logic signed [PW-1:0] b_ext;

  // sign-extend the selected slice of each operand to full product width
  always_comb begin
    if (mode == MODE_WORD) begin
      a_ext = {{(PW-NARROW_W){opnd_a[NARROW_W-1]}}, opnd_a[NARROW_W-1:0]};
      b_ext = {{(PW-NARROW_W){opnd_b[NARROW_W-1]}}, opnd_b[NARROW_W-1:0]};
    end else begin
      a_ext = {{WORD_W{opnd_a[WORD_W-1]}}, opnd_a};
      b_ext = {{WORD_W{opnd_b[WORD_W-1]}}, opnd_b};
    end
  end

  assign prod = a_ext * b_ext;
endmodule

// File: rtl/mac_saturate.sv
module mac_saturate
  import mac_pkg::*;
#(
  parameter int WORD_W = 32
) (
  input  mac_mode_e           mode,
  input  logic                sat_en,
  input  logic [2*WORD_W-1:0] sum,
  output logic [WORD_W-1:0]   hi_out,
  output logic [WORD_W-1:0]   lo_out
);
  localparam int PW   = 2 * WORD_W;
  localparam int HALF = WORD_W / 2;
  localparam int KEEP = HALF - 1;

  logic in_range;
  logic neg;

  assign neg      = sum[PW-1];
  // the sum fits the signed word when its top bits down to the word sign all agree
  assign in_range = (&sum[PW-1:WORD_W-1]) | ~(|sum[PW-1:WORD_W-1]);

  always_comb begin
    hi_out = sum[PW-1:WORD_W];
    lo_out = sum[WORD_W-1:0];
    if (sat_en) begin
      if (mode == MODE_LONG) begin
        if (neg) hi_out[WORD_W-1:HALF] = '1;
        else     hi_out[WORD_W-1:KEEP] = '0;
      end else if (!in_range) begin
        hi_out = WORD_W'(1);
        lo_out = neg ? {1'b1, {(WORD_W-1){1'b0}}} : {1'b0, {(WORD_W-1){1'b1}}};
      end
    end
  end
endmodule

// File: rtl/mac_pair_acc.sv
module mac_pair_acc
  import mac_pkg::*;
#(
  parameter int WORD_W   = 32,
  parameter int NARROW_W = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              op_valid,
  input  logic              op_word,
  input  logic              sat_en,
  input  logic              clr,
  input  logic [WORD_W-1:0] opnd_a,
  input  logic [WORD_W-1:0] opnd_b,
  input  logic              hi_we,
  input  logic [WORD_W-1:0] hi_wdata,
  input  logic              lo_we,
  input  logic [WORD_W-1:0] lo_wdata,
  output logic [WORD_W-1:0] hi_rdata,
  output logic [WORD_W-1:0] lo_rdata
);
  localparam int PW   = 2 * WORD_W;
  localparam int HALF = WORD_W / 2;
  localparam int KEEP = HALF - 1;

  // reset: asserted asynchronously, released after two clock edges
  logic [1:0] rst_sync_q;
  logic       rst_int_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= 2'b00;
    else        rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign rst_int_n = rst_sync_q[1];

  mac_mode_e           mode;
  logic [PW-1:0]       prod;
  logic [PW-1:0]       sum;
  logic [WORD_W-1:0]   sat_hi, sat_lo;
  logic [WORD_W-1:0]   hi_q, lo_q, hi_d, lo_d;
  logic                acc_en;

  assign mode = op_word ? MODE_WORD : MODE_LONG;

  mac_product #(.WORD_W(WORD_W), .NARROW_W(NARROW_W)) u_prod (
    .mode   (mode),
    .opnd_a (opnd_a),
    .opnd_b (opnd_b),
    .prod   (prod)
  );

  assign sum = {hi_q, lo_q} + prod;

  mac_saturate #(.WORD_W(WORD_W)) u_sat (
    .mode   (mode),
    .sat_en (sat_en),
    .sum    (sum),
    .hi_out (sat_hi),
    .lo_out (sat_lo)
  );

  // next state: clear, then direct write, then strobe result
  always_comb begin
    hi_d = hi_q;
    lo_d = lo_q;
    if (clr) begin
      hi_d = '0;
      lo_d = '0;
    end else begin
      if (op_valid) begin
        hi_d = sat_hi;
        lo_d = sat_lo;
      end
      if (hi_we) hi_d = hi_wdata;
      if (lo_we) lo_d = lo_wdata;
    end
  end

  assign acc_en = clr | op_valid | hi_we | lo_we;

  always_ff @(posedge clk or negedge rst_int_n) begin
    if (!rst_int_n) begin
      hi_q <= '0;
      lo_q <= '0;
    end else if (acc_en) begin
      hi_q <= hi_d;
      lo_q <= lo_d;
    end
  end

  assign hi_rdata = hi_q;
  assign lo_rdata = lo_q;

  // R8: clear wins over everything in its cycle
  a_r8_clear_zeroes: assert property (@(posedge clk) disable iff (!rst_int_n)
    clr |=> (hi_q == '0) && (lo_q == '0));

  // R9: a direct write lands in its half
  a_r9_hi_write: assert property (@(posedge clk) disable iff (!rst_int_n)
    (hi_we && !clr) |=> hi_q == $past(hi_wdata));

  a_r9_lo_write: assert property (@(posedge clk) disable iff (!rst_int_n)
    (lo_we && !clr) |=> lo_q == $past(lo_wdata));

  // R10: idle cycles keep the pair
  a_r10_hold_idle: assert property (@(posedge clk) disable iff (!rst_int_n)
    (!clr && !op_valid && !hi_we && !lo_we) |=> $stable(hi_q) && $stable(lo_q));

  // R4: long-mode saturation leaves the upper word sign-filled or masked
  a_r4_long_sat_shape: assert property (@(posedge clk) disable iff (!rst_int_n)
    (op_valid && !op_word && sat_en && !clr && !hi_we)
      |=> (&hi_q[WORD_W-1:HALF]) || (hi_q[WORD_W-1:KEEP] == '0));

  // R5/R6/R7: word-mode saturation leaves a 32-bit value or the overflow marker
  a_r7_word_sat_shape: assert property (@(posedge clk) disable iff (!rst_int_n)
    (op_valid && op_word && sat_en && !clr && !hi_we && !lo_we)
      |=> (hi_q == '0 && !lo_q[WORD_W-1]) || (&hi_q && lo_q[WORD_W-1])
          || (hi_q == WORD_W'(1)));
endmodule

// File: tb/tb_mac_pair_acc.sv
`timescale 1ns/1ps
module tb_mac_pair_acc;
  localparam int W = 32;

  logic         clk = 1'b0;
  logic         rst_n;
  logic         op_valid, op_word, sat_en, clr, hi_we, lo_we;
  logic [W-1:0] opnd_a, opnd_b, hi_wdata, lo_wdata;
  logic [W-1:0] hi_rdata, lo_rdata;

  int errors = 0;
  int checks = 0;
  bit done   = 1'b0;

  always #2 clk = ~clk;

  mac_pair_acc #(.WORD_W(W), .NARROW_W(16)) dut (
    .clk(clk), .rst_n(rst_n), .op_valid(op_valid), .op_word(op_word),
    .sat_en(sat_en), .clr(clr), .opnd_a(opnd_a), .opnd_b(opnd_b),
    .hi_we(hi_we), .hi_wdata(hi_wdata), .lo_we(lo_we), .lo_wdata(lo_wdata),
    .hi_rdata(hi_rdata), .lo_rdata(lo_rdata)
  );

  typedef struct packed {
    logic [7:0]   req;
    logic         word;
    logic         sat;
    logic [W-1:0] hi0;
    logic [W-1:0] lo0;
    logic [W-1:0] a;
    logic [W-1:0] b;
    logic [W-1:0] ehi;
    logic [W-1:0] elo;
  } vec_t;

  localparam int NV = 12;
  localparam vec_t VECS [NV] = '{
    // R2: 3*5
    '{8'd2, 1'b0, 1'b0, 32'h0, 32'h0, 32'd3, 32'd5, 32'h0, 32'd15},
    // R2: -2*3
    '{8'd2, 1'b0, 1'b0, 32'h0, 32'h0, 32'hFFFFFFFE, 32'd3, 32'hFFFFFFFF, 32'hFFFFFFFA},
    // R2: carry into upper word
    '{8'd2, 1'b0, 1'b0, 32'h0, 32'hFFFFFFFF, 32'd1, 32'd1, 32'h1, 32'h0},
    // R2: largest product 2^62
    '{8'd2, 1'b0, 1'b0, 32'h0, 32'h0, 32'h80000000, 32'h80000000, 32'h40000000, 32'h0},
    // R11 / R3: 4 * -3 with garbage upper bits
    '{8'd11, 1'b1, 1'b0, 32'h0, 32'h0, 32'hABCD0004, 32'h1234FFFD, 32'hFFFFFFFF, 32'hFFFFFFF4},
    // R3: crosses 2^31 without clamp
    '{8'd3, 1'b1, 1'b0, 32'h0, 32'h7FFFFFF0, 32'h10, 32'h1, 32'h0, 32'h80000000},
    // R6: sum 2^31 clamps high
    '{8'd6, 1'b1, 1'b1, 32'h0, 32'h7FFFFFF0, 32'h10, 32'h1, 32'h1, 32'h7FFFFFFF},
    // R5: sum -2^31-1 clamps low
    '{8'd5, 1'b1, 1'b1, 32'hFFFFFFFF, 32'h80000000, 32'h1, 32'h0000FFFF, 32'h1, 32'h80000000},
    // R7: in range
    '{8'd7, 1'b1, 1'b1, 32'h0, 32'd100, 32'd2, 32'd3, 32'h0, 32'd106},
    // R7: -32768*-32768 = 2^30 in range
    '{8'd7, 1'b1, 1'b1, 32'h0, 32'h0, 32'h8000, 32'h8000, 32'h0, 32'h40000000},
    // R4: positive, upper word masked to 15 bits
    '{8'd4, 1'b0, 1'b1, 32'h00012345, 32'h0, 32'd1, 32'd1, 32'h00002345, 32'h1},
    // R4: negative, upper half forced to ones
    '{8'd4, 1'b0, 1'b1, 32'h80000000, 32'h0, 32'd1, 32'd1, 32'hFFFF0000, 32'h1}
  };

  task automatic chk(input string tag, input logic [W-1:0] act, input logic [W-1:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%08h expected=%08h", tag, act, exp);
    end
  endtask

  task automatic idle_inputs();
    op_valid = 0; op_word = 0; sat_en = 0; clr = 0; hi_we = 0; lo_we = 0;
    opnd_a = '0; opnd_b = '0; hi_wdata = '0; lo_wdata = '0;
  endtask

  task automatic preset(input logic [W-1:0] h, input logic [W-1:0] l);
    @(negedge clk);
    idle_inputs();
    hi_we = 1; lo_we = 1; hi_wdata = h; lo_wdata = l;
    @(negedge clk);
    idle_inputs();
  endtask

  task automatic strobe(input logic w, input logic s, input logic [W-1:0] a, input logic [W-1:0] b);
    op_valid = 1; op_word = w; sat_en = s; opnd_a = a; opnd_b = b;
    @(negedge clk);
    idle_inputs();
  endtask

  initial begin
    idle_inputs();
    rst_n = 0;
    repeat (3) @(negedge clk);
    rst_n = 1;
    repeat (3) @(negedge clk);
    chk("R1 reset hi", hi_rdata, 32'h0);
    chk("R1 reset lo", lo_rdata, 32'h0);

    for (int i = 0; i < NV; i++) begin
      preset(VECS[i].hi0, VECS[i].lo0);
      strobe(VECS[i].word, VECS[i].sat, VECS[i].a, VECS[i].b);
      chk($sformatf("R%0d vec%0d hi", VECS[i].req, i), hi_rdata, VECS[i].ehi);
      chk($sformatf("R%0d vec%0d lo", VECS[i].req, i), lo_rdata, VECS[i].elo);
    end

    // R2: back-to-back accumulation
    preset(32'h0, 32'h0);
    op_valid = 1; opnd_a = 32'd3; opnd_b = 32'd5;
    @(negedge clk);
    chk("R2 chain first lo", lo_rdata, 32'd15);
    @(negedge clk);
    idle_inputs();
    chk("R2 chain second lo", lo_rdata, 32'd30);

    // R10: idle holds
    repeat (4) @(negedge clk);
    chk("R10 hold lo", lo_rdata, 32'd30);
    chk("R10 hold hi", hi_rdata, 32'h0);

    // R8: clear beats strobe and writes
    preset(32'h1234, 32'h5678);
    clr = 1; op_valid = 1; opnd_a = 32'd7; opnd_b = 32'd7;
    hi_we = 1; hi_wdata = 32'hDEAD;
    @(negedge clk);
    idle_inputs();
    chk("R8 clear hi", hi_rdata, 32'h0);
    chk("R8 clear lo", lo_rdata, 32'h0);

    // R9: write overrides one half, other half takes strobe result
    op_valid = 1; opnd_a = 32'd3; opnd_b = 32'd5;
    hi_we = 1; hi_wdata = 32'h0000BEEF;
    @(negedge clk);
    idle_inputs();
    chk("R9 write hi", hi_rdata, 32'h0000BEEF);
    chk("R9 strobe lo", lo_rdata, 32'd15);

    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog expired");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end
endmodule